// File: doc/BRIEF.md
# Parallel Port IDE Register Bridge

This block sits on the peripheral side of a cable adapter. A host drives an 8-bit data byte and four control lines. The bridge reads those lines and turns them into single accesses on a small IDE register bus. The host selects a register by placing an address byte on the data lines and walking the control lines through a fixed select pattern. It then either stores a byte with a short strobe sequence, or fetches a register and collects it as two 4-bit halves on the upper four status lines.

Both host inputs first pass through a synchroniser. A control value counts only once it has held steady long enough, so slow host edges and short glitches never start an access. The host link has no back-pressure. The host paces every step by holding the control lines. The IDE bus accepts a one-cycle strobe in any cycle and never stalls. Because of this, neither side carries a valid/ready pair.

The bridge also answers a presence probe, which lets the host detect the adapter before connecting to it. A latched byte that selects no register space disconnects the bridge. In that state it releases the status lines.

Top module: `ppib_bridge`

## Requirements
- R1: After reset the status lines are not driven (`pp_stat_oe` = 0), no strobe is active and `ide_cs` = 00.
- R2: A control value counts only after the synchroniser and after it has held for at least two clocks. A value present for a single clock has no effect.
- R3: The control sequence 0xC, 0xE, 0xC, 0x4 latches the data byte. Repeated writes of the same value are not separate steps. In the latched byte, bit 3 alone selects the task-file space (`ide_cs` = 01), bit 4 alone selects the control space (`ide_cs` = 10), and bits 2:0 give `ide_addr`.
- R4: A control value that arrives out of order during the select pattern returns the matcher to its first step. Nothing is latched, and the previous register selection is kept.
- R5: While connected, control 0x6 issues exactly one `ide_rd` pulse and presents bits 3:0 of the read value on `pp_stat`. Control 0x4 after 0x6 then presents bits 7:4 of the same value, with no further strobe.
- R6: While connected, the control sequence 0x5, 0x7, 0x5 issues exactly one `ide_wr` pulse on the final 0x7-to-0x5 change. The pulse carries the data byte present at that moment.
- R7: A latched byte with neither or both of bits 3 and 4 set disconnects the bridge. Byte 0x20 is the usual one. The status lines are released, and read or write sequences issue no strobes until the next valid selection.
- R8: With data 0x04, control 0x6 followed by 0x7 drives the status lines with bit 2 (host status bit 6) low. The next control value 0x4 sets that bit high. Any further control change releases the lines.
- R9: A write followed by a read of the same register returns the written byte for every byte value.
- R10: `ide_rd` and `ide_wr` are never active together, and either one is active only with exactly one chip-select bit set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bridge clock |
| rst_n | input | 1 | Active-low reset |
| pp_data | input | 8 | Host data byte (asynchronous) |
| pp_ctrl | input | 4 | Host control lines (asynchronous) |
| pp_stat | output | 4 | Upper status nibble returned to the host |
| pp_stat_oe | output | 1 | Status lines driven |
| ide_addr | output | 3 | IDE register index |
| ide_cs | output | 2 | Chip selects: bit 0 task file, bit 1 control space |
| ide_rd | output | 1 | One-cycle read strobe |
| ide_wr | output | 1 | One-cycle write strobe |
| ide_wdata | output | 8 | Write data, valid with `ide_wr` |
| ide_rdata | input | 8 | Read data, sampled in the `ide_rd` cycle |

## Verification
A behavioural register array answers the strobes. The main write and read path is tried in two ways. First, it uses distinct preset values in both chip-select spaces, which shows whether the right space and index are decoded. Second, it sweeps every byte with k^0xAA written to one register and k^0x55 to its neighbour. A swapped nibble, a dropped bit or a write to the wrong index then shows up as a mismatch on readback. Further tests cover a one-clock control glitch versus a two-clock hold, select patterns broken at different steps, a disconnect byte followed by full read and write sequences, and the presence probe. Together these separate timing filtering, pattern matching and connection state.

// File: rtl/ppib_pkg.sv
package ppib_pkg;
  localparam int CTRL_W = 4;
  typedef logic [CTRL_W-1:0] ctrl_t;

  // host control codes the bridge reacts to
  localparam ctrl_t C_REST  = 4'h4;
  localparam ctrl_t C_SEL   = 4'hC;
  localparam ctrl_t C_SELAF = 4'hE;
  localparam ctrl_t C_RDLO  = 4'h6;
  localparam ctrl_t C_STB   = 4'h5;
  localparam ctrl_t C_STBAF = 4'h7;

  localparam logic [7:0] ID_PROBE = 8'h04;

  typedef enum logic [1:0] {
    BR_IDLE,
    BR_CONN,
    BR_IDA,
    BR_IDB
  } br_state_t;

  typedef enum logic [1:0] {
    M_WAIT_SEL,
    M_WAIT_AF,
    M_WAIT_SEL2,
    M_WAIT_REST
  } match_step_t;
endpackage

// File: rtl/ppib_line_filter.sv
module ppib_line_filter
  import ppib_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2,
  parameter int STABLE_CLKS = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] data_in,
  input  ctrl_t             ctrl_in,
  output logic [DATA_W-1:0] data_s,
  output logic              ctrl_evt,
  output ctrl_t             ctrl_settled,
  output ctrl_t             ctrl_prev
);
  localparam int W     = CTRL_W + DATA_W;
  localparam int CNT_W = $clog2(STABLE_CLKS + 1);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(STABLE_CLKS);

  logic [SYNC_STAGES-1:0][W-1:0] stage;
  ctrl_t                         s_ctrl;
  ctrl_t                         cand;
  logic [CNT_W-1:0]              cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < SYNC_STAGES; i++) stage[i] <= {C_REST, {DATA_W{1'b0}}};
    end else begin
      stage[0] <= {ctrl_in, data_in};
      for (int i = 1; i < SYNC_STAGES; i++) stage[i] <= stage[i-1];
    end
  end

  assign s_ctrl = stage[SYNC_STAGES-1][W-1:DATA_W];
  assign data_s = stage[SYNC_STAGES-1][DATA_W-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cand         <= C_REST;
      cnt          <= CNT_MAX;
      ctrl_settled <= C_REST;
      ctrl_prev    <= C_REST;
      ctrl_evt     <= 1'b0;
    end else begin
      ctrl_evt <= 1'b0;
      if (s_ctrl != cand) begin
        cand <= s_ctrl;
        cnt  <= CNT_W'(1);
      end else if (cnt < CNT_MAX) begin
        cnt <= cnt + CNT_W'(1);
      end
      if (cnt >= CNT_MAX && cand != ctrl_settled) begin
        ctrl_settled <= cand;
        ctrl_prev    <= ctrl_settled;
        ctrl_evt     <= 1'b1;
      end
    end
  end

  // R2
  evt_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_evt |-> $past(s_ctrl, 2) == ctrl_settled);
endmodule

// File: rtl/ppib_addr_match.sv
module ppib_addr_match
  import ppib_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              evt,
  input  ctrl_t             evt_val,
  input  logic [DATA_W-1:0] data_s,
  output logic              latch_pulse,
  output logic [DATA_W-1:0] latch_byte
);
  match_step_t step;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      step        <= M_WAIT_SEL;
      latch_pulse <= 1'b0;
      latch_byte  <= '0;
    end else begin
      latch_pulse <= 1'b0;
      if (evt) begin
        unique case (step)
          M_WAIT_SEL:  if (evt_val == C_SEL) step <= M_WAIT_AF;
          M_WAIT_AF:   step <= (evt_val == C_SELAF) ? M_WAIT_SEL2 : M_WAIT_SEL;
          M_WAIT_SEL2: step <= (evt_val == C_SEL) ? M_WAIT_REST : M_WAIT_SEL;
          M_WAIT_REST: begin
            step <= M_WAIT_SEL;
            if (evt_val == C_REST) begin
              latch_pulse <= 1'b1;
              latch_byte  <= data_s;
            end
          end
          default:     step <= M_WAIT_SEL;
        endcase
      end
    end
  end

  // R3
  latch_on_rest_chk: assert property (@(posedge clk) disable iff (!rst_n)
    latch_pulse |-> ($past(evt) && $past(evt_val) == C_REST));
endmodule

// File: rtl/ppib_access_engine.sv
module ppib_access_engine
  import ppib_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int IDX_W  = 3,
  parameter int CS_W   = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              evt,
  input  ctrl_t             evt_val,
  input  ctrl_t             evt_prev,
  input  logic [DATA_W-1:0] data_s,
  input  logic              latch_pulse,
  input  logic [DATA_W-1:0] latch_byte,
  input  logic [DATA_W-1:0] ide_rdata,
  output logic [IDX_W-1:0]  ide_addr,
  output logic [CS_W-1:0]   ide_cs,
  output logic              ide_rd,
  output logic              ide_wr,
  output logic [DATA_W-1:0] ide_wdata,
  output logic [3:0]        stat,
  output logic              stat_oe
);
  localparam int HALF = DATA_W / 2;

  br_state_t         state;
  logic [DATA_W-1:0] rbuf;
  logic              wr_arm;
  logic [CS_W-1:0]   sel_cs;
  logic              sel_ok;
  logic              probe_hit;

  assign sel_cs    = latch_byte[IDX_W+CS_W-1:IDX_W];
  assign sel_ok    = ($countones(sel_cs) == 1);
  assign probe_hit = (evt_val == C_STBAF) && (evt_prev == C_RDLO) && (data_s == ID_PROBE);
  assign stat_oe   = (state != BR_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= BR_IDLE;
      ide_addr  <= '0;
      ide_cs    <= '0;
      ide_rd    <= 1'b0;
      ide_wr    <= 1'b0;
      ide_wdata <= '0;
      rbuf      <= '0;
      stat      <= '0;
      wr_arm    <= 1'b0;
    end else begin
      ide_rd <= 1'b0;
      ide_wr <= 1'b0;
      if (ide_rd) begin
        rbuf <= ide_rdata;
        stat <= ide_rdata[HALF-1:0];
      end
      if (latch_pulse) begin
        wr_arm <= 1'b0;
        stat   <= '0;
        if (sel_ok) begin
          state    <= BR_CONN;
          ide_addr <= latch_byte[IDX_W-1:0];
          ide_cs   <= sel_cs;
        end else begin
          state  <= BR_IDLE;
          ide_cs <= '0;
        end
      end else if (evt) begin
        if (probe_hit) begin
          state  <= BR_IDA;
          ide_cs <= '0;
          wr_arm <= 1'b0;
          stat   <= 4'b0000;
        end else begin
          unique case (state)
            BR_CONN: begin
              if (evt_val == C_RDLO) begin
                ide_rd <= 1'b1;
              end else if (evt_val == C_REST) begin
                wr_arm <= 1'b0;
                if (evt_prev == C_RDLO) stat <= rbuf[DATA_W-1:HALF];
              end else if (evt_val == C_STBAF) begin
                wr_arm <= (evt_prev == C_STB);
              end else if (evt_val == C_STB) begin
                if (wr_arm && evt_prev == C_STBAF) begin
                  ide_wr    <= 1'b1;
                  ide_wdata <= data_s;
                  wr_arm    <= 1'b0;
                end
              end
            end
            BR_IDA: begin
              if (evt_val == C_REST) begin
                state <= BR_IDB;
                stat  <= 4'b0100;
              end else begin
                state <= BR_IDLE;
                stat  <= '0;
              end
            end
            BR_IDB: begin
              state <= BR_IDLE;
              stat  <= '0;
            end
            default: ;
          endcase
        end
      end
    end
  end

  // R5
  rd_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ide_rd |=> !ide_rd);

  // R10
  rd_wr_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(ide_rd && ide_wr));

  // R10
  strobe_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ide_rd || ide_wr) |-> $countones(ide_cs) == 1);

  // R7
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !stat_oe |-> (!ide_rd && !ide_wr));
endmodule

// File: rtl/ppib_bridge.sv
module ppib_bridge
  import ppib_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int IDX_W       = 3,
  parameter int CS_W        = 2,
  parameter int SYNC_STAGES = 2,
  parameter int STABLE_CLKS = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] pp_data,
  input  logic [3:0]        pp_ctrl,
  output logic [3:0]        pp_stat,
  output logic              pp_stat_oe,
  output logic [IDX_W-1:0]  ide_addr,
  output logic [CS_W-1:0]   ide_cs,
  output logic              ide_rd,
  output logic              ide_wr,
  output logic [DATA_W-1:0] ide_wdata,
  input  logic [DATA_W-1:0] ide_rdata
);
  logic [DATA_W-1:0] data_s;
  logic              evt;
  ctrl_t             evt_val;
  ctrl_t             evt_prev;
  logic              latch_pulse;
  logic [DATA_W-1:0] latch_byte;

  ppib_line_filter #(
    .DATA_W(DATA_W), .SYNC_STAGES(SYNC_STAGES), .STABLE_CLKS(STABLE_CLKS)
  ) u_filter (
    .clk(clk), .rst_n(rst_n), .data_in(pp_data), .ctrl_in(pp_ctrl),
    .data_s(data_s), .ctrl_evt(evt), .ctrl_settled(evt_val), .ctrl_prev(evt_prev)
  );

  ppib_addr_match #(.DATA_W(DATA_W)) u_match (
    .clk(clk), .rst_n(rst_n), .evt(evt), .evt_val(evt_val), .data_s(data_s),
    .latch_pulse(latch_pulse), .latch_byte(latch_byte)
  );

  ppib_access_engine #(.DATA_W(DATA_W), .IDX_W(IDX_W), .CS_W(CS_W)) u_engine (
    .clk(clk), .rst_n(rst_n), .evt(evt), .evt_val(evt_val), .evt_prev(evt_prev),
    .data_s(data_s), .latch_pulse(latch_pulse), .latch_byte(latch_byte),
    .ide_rdata(ide_rdata), .ide_addr(ide_addr), .ide_cs(ide_cs), .ide_rd(ide_rd),
    .ide_wr(ide_wr), .ide_wdata(ide_wdata), .stat(pp_stat), .stat_oe(pp_stat_oe)
  );
endmodule

// File: tb/sim_ppib_bridge.sv
module sim_ppib_bridge;
  localparam int CLK_PERIOD = 10;
  localparam int HOLD       = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] pp_data = 8'h00;
  logic [3:0] pp_ctrl = 4'h4;
  logic [3:0] pp_stat;
  logic       pp_stat_oe;
  logic [2:0] ide_addr;
  logic [1:0] ide_cs;
  logic       ide_rd, ide_wr;
  logic [7:0] ide_wdata, ide_rdata;

  int n_chk = 0, n_fail = 0;
  int rd_cnt = 0, wr_cnt = 0;
  logic [2:0] w_addr, r_addr;
  logic [1:0] w_cs, r_cs;
  logic [7:0] w_data;
  logic [7:0] bank0 [8];
  logic [7:0] bank1 [8];

  always #(CLK_PERIOD/2) clk = ~clk;

  ppib_bridge u0 (
    .clk(clk), .rst_n(rst_n), .pp_data(pp_data), .pp_ctrl(pp_ctrl),
    .pp_stat(pp_stat), .pp_stat_oe(pp_stat_oe), .ide_addr(ide_addr),
    .ide_cs(ide_cs), .ide_rd(ide_rd), .ide_wr(ide_wr),
    .ide_wdata(ide_wdata), .ide_rdata(ide_rdata)
  );

  assign ide_rdata = (ide_cs == 2'b10) ? bank1[ide_addr] : bank0[ide_addr];

  initial begin
    for (int i = 0; i < 8; i++) begin
      bank0[i] = 8'h30 + 8'(i);
      bank1[i] = 8'hC0 + 8'(i);
    end
    forever begin
      @(posedge clk);
      if (ide_wr) begin
        wr_cnt++;
        w_addr = ide_addr; w_cs = ide_cs; w_data = ide_wdata;
        if (ide_cs == 2'b10) bank1[ide_addr] = ide_wdata;
        else bank0[ide_addr] = ide_wdata;
      end
      if (ide_rd) begin
        rd_cnt++;
        r_addr = ide_addr; r_cs = ide_cs;
      end
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic step(input logic [3:0] c);
    @(negedge clk); pp_ctrl = c;
    repeat (HOLD) @(negedge clk);
  endtask

  task automatic put_data(input logic [7:0] d);
    @(negedge clk); pp_data = d;
  endtask

  task automatic host_addr(input logic [7:0] b);
    put_data(b); step(4'hC); step(4'hE); step(4'hC); step(4'h4);
  endtask

  task automatic host_write(input logic [7:0] b);
    put_data(b); step(4'h5); step(4'h7); step(4'h5); step(4'h4);
  endtask

  task automatic host_read(output logic [7:0] v);
    logic [3:0] lo;
    step(4'h6); lo = pp_stat;
    step(4'h4); v = {pp_stat, lo};
  endtask

  task automatic t_reset();
    check(pp_stat_oe == 1'b0, "R1", "stat_oe", pp_stat_oe, 0);
    check(!ide_rd && !ide_wr, "R1", "strobes", {ide_rd, ide_wr}, 0);
    check(ide_cs == 2'b00, "R1", "cs", ide_cs, 0);
  endtask

  task automatic t_taskfile();
    int w0, r0; logic [7:0] v;
    host_addr(8'h0A);
    check(pp_stat_oe == 1'b1, "R3", "connected oe", pp_stat_oe, 1);
    w0 = wr_cnt;
    host_write(8'h5A);
    check(wr_cnt == w0 + 1, "R6", "one write strobe", wr_cnt - w0, 1);
    check(w_cs == 2'b01 && w_addr == 3'd2, "R3", "write cs/addr", {w_cs, w_addr}, {2'b01, 3'd2});
    check(w_data == 8'h5A, "R6", "write data", w_data, 8'h5A);
    r0 = rd_cnt;
    host_read(v);
    check(rd_cnt == r0 + 1, "R5", "one read strobe", rd_cnt - r0, 1);
    check(v == 8'h5A, "R5", "nibble readback", v, 8'h5A);
  endtask

  task automatic t_ctrl_space();
    logic [7:0] v;
    host_addr(8'h16);
    host_read(v);
    check(r_cs == 2'b10 && r_addr == 3'd6, "R3", "read cs/addr", {r_cs, r_addr}, {2'b10, 3'd6});
    check(v == 8'hC6, "R5", "control space read", v, 8'hC6);
  endtask

  task automatic t_glitch();
    int r0;
    host_addr(8'h0B);
    r0 = rd_cnt;
    @(negedge clk); pp_ctrl = 4'h6;
    @(negedge clk); pp_ctrl = 4'h4;
    repeat (HOLD) @(negedge clk);
    check(rd_cnt == r0, "R2", "1-clock glitch ignored", rd_cnt - r0, 0);
    @(negedge clk); pp_ctrl = 4'h6;
    repeat (2) @(negedge clk); pp_ctrl = 4'h4;
    repeat (HOLD) @(negedge clk);
    check(rd_cnt == r0 + 1, "R2", "2-clock hold accepted", rd_cnt - r0, 1);
  endtask

  task automatic t_bad_pattern();
    host_addr(8'h0A);
    put_data(8'h0B); step(4'hC); step(4'hE); step(4'h4);
    put_data(8'h0B); step(4'hC); step(4'h4);
    host_write(8'h77);
    check(w_addr == 3'd2, "R4", "selection kept after broken pattern", w_addr, 2);
    host_addr(8'h0B);
    host_write(8'h78);
    check(w_addr == 3'd3, "R4", "matcher recovers", w_addr, 3);
  endtask

  task automatic t_disconnect();
    int r0, w0; logic [7:0] v;
    host_addr(8'h20);
    check(pp_stat_oe == 1'b0, "R7", "released after 0x20", pp_stat_oe, 0);
    r0 = rd_cnt; w0 = wr_cnt;
    host_read(v);
    host_write(8'h11);
    check(rd_cnt == r0 && wr_cnt == w0, "R7", "no strobes disconnected",
          (rd_cnt - r0) + (wr_cnt - w0), 0);
    check(pp_stat_oe == 1'b0, "R7", "still released", pp_stat_oe, 0);
  endtask

  task automatic t_chip_id();
    put_data(8'h04); step(4'h6); step(4'h7);
    check(pp_stat_oe == 1'b1, "R8", "probe drives", pp_stat_oe, 1);
    check(pp_stat[2] == 1'b0, "R8", "bit6 low", pp_stat[2], 0);
    step(4'h4);
    check(pp_stat[2] == 1'b1, "R8", "bit6 high", pp_stat[2], 1);
    step(4'hC); step(4'hE); step(4'h4);
    check(pp_stat_oe == 1'b0, "R8", "probe released", pp_stat_oe, 0);
  endtask

  task automatic t_sweep();
    logic [7:0] v;
    for (int k = 0; k < 256; k++) begin
      host_addr(8'h0A); host_write(8'(k) ^ 8'hAA);
      host_addr(8'h0B); host_write(8'(k) ^ 8'h55);
      host_addr(8'h0A); host_read(v);
      check(v == (8'(k) ^ 8'hAA), "R9", "sweep readback", v, 8'(k) ^ 8'hAA);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_taskfile();
    t_ctrl_space();
    t_glitch();
    t_bad_pattern();
    t_disconnect();
    t_chip_id();
    t_sweep();
    summary();
    $finish;
  end
endmodule